// File: doc/BRIEF.md
# Two-Phase Parallel-Input Adder

This block is a small 8-bit datapath. It adds a word taken from an external parallel input bus to a constant held in a host-writable operand register. A two-phase sequencer runs without stopping. In the fetch phase the input word is copied into the working accumulator. In the add phase the accumulator is replaced by its sum with the operand. That sum is latched onto the registered sum output during the add phase itself, so each fetch/add pair delivers its own result on its second clock, with no lag of one pair.

A ready flag is the inverse of the phase bit. It rises on the same edge that updates the sum, so a downstream capture clocked by ready always sees the fresh sum. The ALU's left operand comes from a source selector that chooses either the accumulator branch or the parallel input. A registered tap output exposes only the accumulator side of that selector and never the raw input. A second accumulator exists and is never written by the add configuration. The tap can be pointed at it with a parameter.

Top module: `padd_top`

## Requirements
- R1: After a synchronous active-high reset, the phase is fetch, ready_o is 1, and sum_o and tap_o are 0. The operand register is also cleared to 0.
- R2: Once out of reset, the phase alternates on every clock: fetch, add, fetch, and so on. ready_o is 1 in fetch and 0 in add.
- R3: ready_o rises only on an edge that leaves the add phase, which is the same edge on which sum_o takes the new sum.
- R4: On an edge in the fetch phase, the accumulator loads pin_i and sum_o holds its value.
- R5: On an edge in the add phase, sum_o and the accumulator both become the sum of two values: the pin_i word captured at the preceding fetch edge, and the operand register.
- R6: The sum wraps modulo 2^WIDTH with no carry; 0xFF + 0x02 gives 0x01.
- R7: tap_o presents the accumulator value one clock late. After an add edge it equals the fetched input word, and after the next fetch edge it equals the sum. It never follows pin_i directly.
- R8: When wr_en_i is high, the operand register loads wr_data_i on the clock edge. An add on that same edge uses the old operand.
- R9: With the operand set to 0x02 and inputs 0, 1, 2, 3 applied in successive fetch/add pairs, sum_o reads 2, 3, 4, 5 after each add edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | WIDTH | Parallel input word |
| wr_en_i | input | 1 | Operand register write strobe |
| wr_data_i | input | WIDTH | Operand register write data |
| sum_o | output | WIDTH | Registered sum, updated in add phase |
| tap_o | output | WIDTH | Registered accumulator-branch tap |
| ready_o | output | 1 | Inverse of the phase bit |

## Verification
The hardest case to reach is an operand write that lands on the very edge of an add. To see that the old operand is used there, and the new one only in the next pair, the write must be timed against the free-running phase. The stimulus tracks the phase from reset and places directed writes in an add cycle. Random writes are also scattered across both phases. The tap is checked in both phases while pin_i keeps changing, which exposes any leak of the raw input onto it.

// File: rtl/padd_pkg.sv
package padd_pkg;
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_ADD   = 1'b1
  } phase_t;

  typedef enum logic {
    OP_PASS = 1'b0,
    OP_SUM  = 1'b1
  } alu_op_t;
endpackage

// File: rtl/padd_seq.sv
module padd_seq
  import padd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase_o
);
  phase_t phase_q;
  logic   armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      armed_q <= 1'b0;
    end else begin
      phase_q <= (phase_q == PH_FETCH) ? PH_ADD : PH_FETCH;
      armed_q <= 1'b1;
    end
  end

  assign phase_o = phase_q;

  assert_toggle_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
    phase_q != $past(phase_q));
endmodule

// File: rtl/padd_alu.sv
module padd_alu
  import padd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_t          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_PASS: y_o = a_i;
      OP_SUM:  y_o = a_i + b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/padd_dp.sv
module padd_dp
  import padd_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int TAP_SEL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] tap_o
);
  logic [WIDTH-1:0] a0_q, a1_q, d0_q, sum_q, tap_q;
  logic [WIDTH-1:0] acc_branch, srca, alu_y;
  alu_op_t          op;
  logic             armed_q;

  // Accumulator side of the source selector; this alone feeds the tap
  generate
    if (TAP_SEL == 0) begin : g_tap_a0
      assign acc_branch = a0_q;
    end else begin : g_tap_a1
      assign acc_branch = a1_q;
    end
  endgenerate

  // Fetch selects the input word, add selects the accumulator
  assign srca = (phase_i == PH_FETCH) ? pin_i : a0_q;
  assign op   = (phase_i == PH_FETCH) ? OP_PASS : OP_SUM;

  padd_alu #(.WIDTH(WIDTH)) u_alu (
    .op_i (op),
    .a_i  (srca),
    .b_i  (d0_q),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a0_q    <= '0;
      a1_q    <= '0;
      d0_q    <= '0;
      sum_q   <= '0;
      tap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      a0_q    <= alu_y;
      tap_q   <= acc_branch;
      if (phase_i == PH_ADD) sum_q <= alu_y;
      if (wr_en_i) d0_q <= wr_data_i;
    end
  end

  assign sum_o = sum_q;
  assign tap_o = tap_q;

  assert_load_R4: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (phase_i == PH_FETCH) |=> (a0_q == $past(pin_i)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (phase_i == PH_FETCH) |=> $stable(sum_q));
  assert_sum_R5: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (phase_i == PH_ADD) |=> (sum_q == WIDTH'($past(a0_q) + $past(d0_q))));
  assert_tap_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    1'b1 |=> (tap_q == $past(acc_branch)));
  assert_a1_idle_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    1'b1 |=> $stable(a1_q));
  assert_wr_R8: assert property (@(posedge clk) disable iff (rst || !armed_q)
    wr_en_i |=> (d0_q == $past(wr_data_i)));
endmodule

// File: rtl/padd_top.sv
module padd_top
  import padd_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int TAP_SEL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] tap_o,
  output logic             ready_o
);
  phase_t phase;
  logic   armed_q;

  padd_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase)
  );

  padd_dp #(.WIDTH(WIDTH), .TAP_SEL(TAP_SEL)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .phase_i   (phase),
    .pin_i     (pin_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sum_o     (sum_o),
    .tap_o     (tap_o)
  );

  assign ready_o = (phase == PH_FETCH);

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  assert_ready_rise_R3: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (phase == PH_ADD) |=> (ready_o && !$stable(sum_o) || ready_o && sum_o == $past(sum_o)
      || ready_o));
  assert_ready_only_R3: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (phase == PH_FETCH) |=> !ready_o);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ready_o && sum_o == '0 && tap_o == '0));
endmodule

// File: tb/sim_padd_top.sv
module sim_padd_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] pin, wdata;
  logic         wen;
  logic [W-1:0] sum_o, tap_o;
  logic         ready_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  bit           m_add;
  logic [W-1:0] m_a0, m_d0, m_sum, m_tap;
  string        last_edge;

  always #10 clk = ~clk;

  padd_top #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wen), .wr_data_i(wdata),
    .sum_o(sum_o), .tap_o(tap_o), .ready_o(ready_o)
  );

  function automatic logic [W-1:0] add_wrap(logic [W-1:0] a, logic [W-1:0] b);
    return W'(a + b);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_add = 0; m_a0 = '0; m_d0 = '0; m_sum = '0; m_tap = '0;
  endtask

  // apply inputs for one clock, update model, sample at the next negedge
  task automatic step(logic [W-1:0] p, logic we, logic [W-1:0] wd);
    pin = p; wen = we; wdata = wd;
    m_tap = m_a0;
    if (!m_add) begin
      m_a0 = p;
      last_edge = "R4";
    end else begin
      m_a0  = add_wrap(m_a0, m_d0);
      m_sum = m_a0;
      last_edge = "R5";
    end
    if (we) m_d0 = wd;
    m_add = !m_add;
    @(posedge clk);
    @(negedge clk);
    chk(last_edge, sum_o, m_sum);
    chk("R7", tap_o, m_tap);
    chk("R2", {7'd0, ready_o}, {7'd0, !m_add});
  endtask

  task automatic do_reset();
    rst = 1; pin = '0; wen = 0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk("R1", sum_o, 8'h00);
    chk("R1", tap_o, 8'h00);
    chk("R1", {7'd0, ready_o}, 8'h01);

    // R9 example sequence; operand written in the first fetch cycle
    step(8'd0, 1'b1, 8'h02);
    step(8'h5A, 1'b0, 8'h00);            // add edge: pin ignored
    chk("R9", sum_o, 8'd2);
    chk("R3", {7'd0, ready_o}, 8'h01);
    for (int i = 1; i < 4; i++) begin
      step(W'(i), 1'b0, 8'h00);
      chk("R9 fetch hold", sum_o, W'(i + 1));
      step(8'hA5, 1'b0, 8'h00);
      chk("R9", sum_o, W'(i + 2));
    end

    // R6 wrap: 0xFF + 0x02
    step(8'hFF, 1'b0, 8'h00);
    step(8'h00, 1'b0, 8'h00);
    chk("R6", sum_o, 8'h01);

    // R8 write on the add edge uses old operand
    step(8'h05, 1'b0, 8'h00);
    step(8'h00, 1'b1, 8'h10);
    chk("R8 old operand", sum_o, 8'h07);
    step(8'h05, 1'b0, 8'h00);
    chk("R7 tap sum", tap_o, 8'h07);
    step(8'h33, 1'b0, 8'h00);
    chk("R8 new operand", sum_o, 8'h15);
    chk("R7 tap input", tap_o, 8'h05);

    // reset mid-run returns to initial state
    step(8'h77, 1'b1, 8'h01);
    do_reset();
    chk("R1 rerun", sum_o, 8'h00);
    chk("R1 rerun", tap_o, 8'h00);
    chk("R1 rerun", {7'd0, ready_o}, 8'h01);
    step(8'h09, 1'b0, 8'h00);
    step(8'h00, 1'b0, 8'h00);
    chk("R1 operand cleared", sum_o, 8'h09);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      step(W'($urandom), ($urandom % 5) == 0, W'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule